// File: doc/BRIEF.md
# CPU Memory Banking Controller

This block extends an 8-bit 6502-style computer to 320 KB of RAM held in a single 512 KB external SRAM. The host's own RAM is switched off, so every RAM access, base memory included, is steered into the SRAM. Software picks one of 16 extended 16 KB banks and turns banking on or off by writing a control byte to the port at `$D301`. The bank number is spread over four non-adjacent data bits, and a fifth bit is an active-low enable.

The controller runs on a fast system clock and treats phi2 as an input. It synchronises phi2 to detect the end of each bus cycle. It keeps the address, data and direction sampled while phi2 was high, and commits a port write only once the synchronised falling edge of phi2 arrives. The upper SRAM address bits and the active-low chip select are combinational from the CPU address, phi2 and the stored register. When banking is on and the CPU addresses `$4000`-`$7FFF`, the selected bank is mapped in. Every other RAM access goes to a fixed 64 KB base region. Only CPU accesses are mapped; there is no separate path for video DMA.

Top module: `mbk_ctrl`

## Requirements
- R1: While reset is held, and after it is released, the register reads as banking disabled with bank 15. A probe of `$4000` then gives `sram_addr_o` = 5'b10001.
- R2: A write (rw_i=0) to `$D301` stores data bits 2, 3, 5 and 6 as bank bits 0, 1, 2 and 3. Bank bit k drives `sram_addr_o[k]` (SRAM A14+k) for a banked access. Data bits 0, 1 and 7 have no effect.
- R3: Data bit 4 of that write is the enable, active low: 0 turns banking on and 1 turns it off.
- R4: The write takes effect at the (SYNC_STAGES+1)-th rising clock edge after phi2 falls, and not before. It uses the address, data and direction that were sampled while phi2 was high, even if the bus changes after phi2 falls.
- R5: A read of `$D301` (rw_i=1) does not change the register, and neither does a write to any other address.
- R6: With banking on, an address in `$4000`-`$7FFF` gives `sram_addr_o` = {1'b0, bank}. The stored bank drives bits [3:0], so SRAM A18 is 0.
- R7: With banking off, or for any address outside the window, `sram_addr_o` = {3'b100, addr_i[15:14]}, which is the 64 KB base region.
- R8: `sram_ce_no` is low only while phi2_i is 1 and addr_i[15:14] != 2'b11. I/O at `$D000`-`$D7FF` and ROM at `$C000`-`$FFFF` never select the SRAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than phi2 |
| rst_ni | input | 1 | Asynchronous reset, active low |
| phi2_i | input | 1 | CPU bus phase clock, high during the data phase |
| addr_i | input | 16 | CPU address bus |
| data_i | input | 8 | CPU data bus, write data |
| rw_i | input | 1 | 1 = read, 0 = write |
| sram_addr_o | output | 5 | SRAM address bits A18..A14 |
| sram_ce_no | output | 1 | SRAM chip select, active low |

## Verification
The SRAM address bits and the chip select follow addr_i, phi2_i and the stored register in the same cycle. The bench sets the inputs on a falling clock edge and reads these outputs 1 ns later. A port write becomes visible SYNC_STAGES+1 rising edges after phi2 drops. The bench checks the old mapping after SYNC_STAGES edges and the new mapping one edge later, and it changes the bus to junk values right after phi2 falls. Each write is followed by address probes inside and outside the window, compared against a bench model of the register.

// File: rtl/mbk_pkg.sv
package mbk_pkg;
  localparam int unsigned BANK_W  = 4;            // 16 banks of 16 KB
  localparam int unsigned PAGE_W  = 2;            // 16 KB pages of 64 KB space
  localparam int unsigned SRAM_HI_W = BANK_W + 1; // SRAM A18..A14
  localparam int unsigned EN_BIT  = 4;            // active-low enable

  typedef struct packed {
    logic              dis;   // 1 = banking off
    logic [BANK_W-1:0] bank;
  } bank_reg_t;

  localparam bank_reg_t BANK_RST = '{dis: 1'b1, bank: '1};

  // scattered bank field: bits 2,3,5,6 -> bank[0..3]
  function automatic logic [BANK_W-1:0] pick_bank(input logic [7:0] d);
    return {d[6], d[5], d[3], d[2]};
  endfunction
endpackage

// File: rtl/mbk_phi2_sync.sv
module mbk_phi2_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic phi2_i,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) sync_q[0] <= 1'b0;
          else         sync_q[0] <= phi2_i;
      end else begin : g_rest
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) sync_q[i] <= 1'b0;
          else         sync_q[i] <= sync_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= sync_q[STAGES-1];

  assign fall_o = last_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/mbk_bus_capture.sv
module mbk_bus_capture #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              phi2_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              rw_i,
  output logic [ADDR_W-1:0] cap_addr_o,
  output logic [DATA_W-1:0] cap_data_o,
  output logic              cap_rw_o
);
  // last sample taken inside the phi2-high phase; held across the sync delay
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_addr_o <= '0;
      cap_data_o <= '0;
      cap_rw_o   <= 1'b1;
    end else if (phi2_i) begin
      cap_addr_o <= addr_i;
      cap_data_o <= data_i;
      cap_rw_o   <= rw_i;
    end
  end
endmodule

// File: rtl/mbk_port_reg.sv
module mbk_port_reg
  import mbk_pkg::*;
#(
  parameter int unsigned             ADDR_W    = 16,
  parameter logic [ADDR_W-1:0]       PORT_ADDR = 16'hD301
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic [ADDR_W-1:0] cap_addr_i,
  input  logic [7:0]        cap_data_i,
  input  logic              cap_rw_i,
  output bank_reg_t         reg_o
);
  logic hit_w;
  logic unused_bits;

  assign hit_w       = commit_i && !cap_rw_i && (cap_addr_i == PORT_ADDR);
  assign unused_bits = ^{cap_data_i[7], cap_data_i[1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_o <= BANK_RST;
    end else if (hit_w) begin
      reg_o.bank <= pick_bank(cap_data_i);
      reg_o.dis  <= cap_data_i[EN_BIT];
    end
  end
endmodule

// File: rtl/mbk_addr_map.sv
module mbk_addr_map
  import mbk_pkg::*;
#(
  parameter logic [PAGE_W-1:0] WIN_PAGE = 2'b01,   // $4000-$7FFF
  parameter logic [PAGE_W-1:0] ROM_PAGE = 2'b11    // $C000-$FFFF: I/O + ROM
) (
  input  logic [PAGE_W-1:0]    page_i,
  input  logic                 phi2_i,
  input  bank_reg_t            reg_i,
  output logic [SRAM_HI_W-1:0] sram_addr_o,
  output logic                 sram_ce_no
);
  localparam int unsigned PAD_W = SRAM_HI_W - PAGE_W - 1;

  logic banked_w;

  assign banked_w = !reg_i.dis && (page_i == WIN_PAGE);

  always_comb begin
    if (banked_w) sram_addr_o = {1'b0, reg_i.bank};
    else          sram_addr_o = {1'b1, {PAD_W{1'b0}}, page_i};
  end

  assign sram_ce_no = !(phi2_i && (page_i != ROM_PAGE));
endmodule

// File: rtl/mbk_ctrl.sv
module mbk_ctrl
  import mbk_pkg::*;
#(
  parameter int unsigned       ADDR_W      = 16,
  parameter int unsigned       DATA_W      = 8,
  parameter int unsigned       SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] PORT_ADDR   = 16'hD301
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 phi2_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    data_i,
  input  logic                 rw_i,
  output logic [SRAM_HI_W-1:0] sram_addr_o,
  output logic                 sram_ce_no
);
  logic              commit_w;
  logic [ADDR_W-1:0] cap_addr_w;
  logic [DATA_W-1:0] cap_data_w;
  logic              cap_rw_w;
  bank_reg_t         reg_w;

  mbk_phi2_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .phi2_i (phi2_i),
    .fall_o (commit_w)
  );

  mbk_bus_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .phi2_i     (phi2_i),
    .addr_i     (addr_i),
    .data_i     (data_i),
    .rw_i       (rw_i),
    .cap_addr_o (cap_addr_w),
    .cap_data_o (cap_data_w),
    .cap_rw_o   (cap_rw_w)
  );

  mbk_port_reg #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) u_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .commit_i   (commit_w),
    .cap_addr_i (cap_addr_w),
    .cap_data_i (cap_data_w[7:0]),
    .cap_rw_i   (cap_rw_w),
    .reg_o      (reg_w)
  );

  mbk_addr_map u_map (
    .page_i      (addr_i[ADDR_W-1 -: PAGE_W]),
    .phi2_i      (phi2_i),
    .reg_i       (reg_w),
    .sram_addr_o (sram_addr_o),
    .sram_ce_no  (sram_ce_no)
  );
endmodule

// File: rtl/mbk_ctrl_chk.sv
module mbk_ctrl_chk
  import mbk_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 16,
  parameter int unsigned       DATA_W    = 8,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'hD301
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 phi2_i,
  input logic [ADDR_W-1:0]    addr_i,
  input logic [SRAM_HI_W-1:0] sram_addr_o,
  input logic                 sram_ce_no,
  input logic                 commit_w,
  input logic [ADDR_W-1:0]    cap_addr_w,
  input logic [DATA_W-1:0]    cap_data_w,
  input logic                 cap_rw_w,
  input bank_reg_t            reg_w
);
  logic [1:0] pg;
  logic       port_wr;
  assign pg      = addr_i[ADDR_W-1 -: 2];
  assign port_wr = commit_w && !cap_rw_w && (cap_addr_w == PORT_ADDR);

  AST_HOLD_NO_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_w |=> $stable(reg_w)); // R4
  AST_BANK_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_wr |=> reg_w.bank == {$past(cap_data_w[6]), $past(cap_data_w[5]),
                               $past(cap_data_w[3]), $past(cap_data_w[2])}); // R2
  AST_EN_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_wr |=> reg_w.dis == $past(cap_data_w[4])); // R3
  AST_OTHER_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_w && !port_wr) |=> $stable(reg_w)); // R5
  AST_WIN_BANKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pg == 2'b01 && !reg_w.dis) |-> sram_addr_o == {1'b0, reg_w.bank}); // R6
  AST_BASE_MAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pg != 2'b01 || reg_w.dis) |-> sram_addr_o == {3'b100, pg}); // R7
  AST_CE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!phi2_i || pg == 2'b11) |-> sram_ce_no); // R8
  AST_CE_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phi2_i && pg != 2'b11) |-> !sram_ce_no); // R8
endmodule

bind mbk_ctrl mbk_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORT_ADDR(PORT_ADDR)
) u_chk (.*);

// File: tb/mbk_ctrl_tb_top.sv
module mbk_ctrl_tb_top;
  localparam int unsigned SYNC = 2;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        phi2_i = 1'b0;
  logic [15:0] addr_i = 16'h0000;
  logic [7:0]  data_i = 8'h00;
  logic        rw_i = 1'b1;
  logic [4:0]  sram_addr_o;
  logic        sram_ce_no;

  int n_chk = 0;
  int n_fail = 0;
  logic [3:0] m_bank = 4'hF;
  logic       m_dis  = 1'b1;

  mbk_ctrl #(.SYNC_STAGES(SYNC)) dut_i (.*);

  always #10 clk_i = ~clk_i;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] exp_map(input logic [15:0] a);
    if (!m_dis && a[15:14] == 2'b01) return {1'b0, m_bank};
    return {3'b100, a[15:14]};
  endfunction

  task automatic probe(input string req, input logic [15:0] a);
    @(negedge clk_i); addr_i = a; #1;
    check(req, {3'b0, sram_addr_o}, {3'b0, exp_map(a)});
  endtask

  // returns just after phi2 falls; bus still holds the cycle's values
  task automatic bus_cycle(input logic [15:0] a, input logic [7:0] d, input logic r);
    @(negedge clk_i); phi2_i = 1'b0; addr_i = a; data_i = d; rw_i = r;
    @(negedge clk_i); phi2_i = 1'b1;
    repeat (3) @(negedge clk_i);
    phi2_i = 1'b0;
  endtask

  task automatic cycle_settle(input logic [15:0] a, input logic [7:0] d, input logic r);
    bus_cycle(a, d, r);
    @(negedge clk_i); addr_i = 16'h0000; data_i = 8'hFF; rw_i = 1'b1;
    repeat (SYNC) @(negedge clk_i);
  endtask

  task automatic write_port(input logic [7:0] d);
    cycle_settle(16'hD301, d, 1'b0);
    m_bank = {d[6], d[5], d[3], d[2]};
    m_dis  = d[4];
  endtask

  task automatic t_reset;
    rst_ni = 1'b0; #1;
    check("R1 in reset", {3'b0, sram_addr_o}, 8'h10);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    probe("R1 after reset $4000", 16'h4000);
    check("R1 value", {3'b0, sram_addr_o}, 8'h11);
    check("R8 ce idle", {7'b0, sram_ce_no}, 8'h01);
  endtask

  task automatic t_bank_bits;
    write_port(8'h04); probe("R2 bit2->A14", 16'h4000);
    write_port(8'h08); probe("R2 bit3->A15", 16'h5000);
    write_port(8'h20); probe("R2 bit5->A16", 16'h6000);
    write_port(8'h40); probe("R2 bit6->A17", 16'h7FFF);
    write_port(8'h83); probe("R2 bits 0,1,7 ignored", 16'h4000);
    check("R2 bank zero", {3'b0, sram_addr_o}, 8'h00);
    write_port(8'h6C); probe("R6 bank15 window", 16'h4ABC);
  endtask

  task automatic t_enable;
    write_port(8'h24); probe("R6 window bank5", 16'h4000);
    check("R6 value", {3'b0, sram_addr_o}, 8'h05);
    probe("R7 below window", 16'h3FFF);
    probe("R7 above window", 16'h8000);
    probe("R7 page0", 16'h0000);
    write_port(8'h34); probe("R3 bit4=1 disables", 16'h4000);
    check("R3 value", {3'b0, sram_addr_o}, 8'h11);
    write_port(8'h24); probe("R3 bit4=0 enables", 16'h4000);
  endtask

  task automatic t_timing;
    write_port(8'h24);
    bus_cycle(16'hD301, 8'h48, 1'b0);
    @(negedge clk_i); addr_i = 16'h4000; data_i = 8'h00; rw_i = 1'b0;
    repeat (SYNC - 1) @(negedge clk_i);
    #1 check("R4 old before commit", {3'b0, sram_addr_o}, 8'h05);
    @(negedge clk_i); #1;
    check("R4 new after commit", {3'b0, sram_addr_o}, 8'h0A);
    m_bank = 4'hA; m_dis = 1'b0;
    rw_i = 1'b1;
    repeat (SYNC + 1) @(negedge clk_i);
    probe("R4 junk after fall ignored", 16'h4000);
  endtask

  task automatic t_ignore;
    write_port(8'h24);
    cycle_settle(16'hD301, 8'h58, 1'b1); probe("R5 read of port", 16'h4000);
    cycle_settle(16'hD300, 8'h58, 1'b0); probe("R5 write D300", 16'h4000);
    cycle_settle(16'hD311, 8'h10, 1'b0); probe("R5 write D311", 16'h4000);
    cycle_settle(16'h4000, 8'h10, 1'b0); probe("R5 write RAM", 16'h4000);
    check("R5 value", {3'b0, sram_addr_o}, 8'h05);
  endtask

  task automatic ce_at(input logic [15:0] a, input logic exp);
    @(negedge clk_i); addr_i = a; rw_i = 1'b1; phi2_i = 1'b1; #1;
    check($sformatf("R8 ce at %04h", a), {7'b0, sram_ce_no}, {7'b0, exp});
    @(negedge clk_i); phi2_i = 1'b0; #1;
    check("R8 ce phi2 low", {7'b0, sram_ce_no}, 8'h01);
  endtask

  task automatic t_ce;
    ce_at(16'h0000, 1'b0);
    ce_at(16'h4000, 1'b0);
    ce_at(16'hBFFF, 1'b0);
    ce_at(16'hC000, 1'b1);
    ce_at(16'hD000, 1'b1);
    ce_at(16'hD7FF, 1'b1);
    ce_at(16'hE000, 1'b1);
  endtask

  task automatic t_mid_reset;
    write_port(8'h24);
    @(negedge clk_i); addr_i = 16'h4000; rst_ni = 1'b0; #1;
    check("R1 async reset", {3'b0, sram_addr_o}, 8'h11);
    m_bank = 4'hF; m_dis = 1'b1;
    @(negedge clk_i); rst_ni = 1'b1;
    probe("R1 after mid reset", 16'h4000);
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_bank_bits();
    t_enable();
    t_timing();
    t_ignore();
    t_ce();
    t_mid_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule